// File: doc/BRIEF.md
# Synchronous 65xx-Bus Register Slave

This block lets a small bank of byte-wide registers sit on a 65xx-style processor bus (PHI2 clock, read/write line, active-low chip select, a few address lines and a data bus). A system clock that is at least eight times faster than PHI2 oversamples every bus input through two-flop synchronizers. Rising and falling edges of the synchronized PHI2 frame each bus access. From that window the block produces active-low read and write strobes in the style of a split-strobe peripheral bus. It drives read data onto the bus only while a selected read is under way, and it stores write data into the addressed register when PHI2 falls.

The data bus is presented as three plain signals: input data, output data and an output enable. The pad-level tri-state buffer sits outside this block. For hosts whose address lines settle late, a delay mode holds off the start of the active phase by one to three system clocks after the PHI2 rise. The active phase still ends at the PHI2 fall. If PHI2 falls before the delayed start, the access is dropped. All bus signals are control-level. There is no streaming data path, so no valid/ready handshake exists and no back-pressure applies.

Top module: `bus65_periph`

## Requirements
- R1: With chip select active and the read/write line high (read), `rd_strobe_n` goes low on the third system clock edge after PHI2 goes high and returns high on the third edge after PHI2 goes low. Otherwise it stays high.
- R2: With chip select active and the read/write line low (write), `wr_strobe_n` follows the same window as R1. The two strobes are never low together.
- R3: `data_oe` is high exactly over the window of a selected read. It never rises before PHI2 has risen, and it falls only after PHI2 has fallen.
- R4: A selected write stores into the addressed register the data present when PHI2 falls. A change of the data lines one clock after the fall does not affect the stored value.
- R5: With chip select high (inactive), neither strobe asserts, `data_oe` stays low and no register changes.
- R6: Changes on address, chip select and read/write while PHI2 is low cause no strobe, no output enable and no register change.
- R7: Address values 0 to 3 select four 8-bit registers. A read of address 4 to 7 returns 0xFF, and a write there changes no register.
- R8: With `delay_en` high, the window opens `delay_sel` clocks later than in R1 (a `delay_sel` of 0 counts as 1). The window still closes as in R1.
- R9: In delay mode, if PHI2 is high for no more clock edges than the delay, the access is dropped: no strobe, no output enable, no write.
- R10: Reset clears every register to 0, holds both strobes high and holds `data_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the PHI2 rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Bus phase-2 clock |
| rw | input | 1 | High for read, low for write |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 3 | Register address |
| data_in | input | 8 | Data lines as seen from the bus |
| data_out | output | 8 | Read data to drive onto the bus |
| data_oe | output | 1 | High while `data_out` must be driven |
| delay_en | input | 1 | Enables the late-start mode |
| delay_sel | input | 2 | Late-start delay in system clocks (0 acts as 1) |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |

## Verification
The delayed start of an access and the detected PHI2 fall can land in the same system clock. This happens when PHI2 is held high for exactly as many clock edges as the programmed delay. The bench provokes this with a delay of 3 and a three-edge high phase, and it judges the result by both strobes and the output enable staying inactive, with a later read-back showing the target register unchanged. A four-edge high phase is also run, where the access must open for one clock and the write must land.

// File: rtl/bus65_pkg.sv
package bus65_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

endpackage

// File: rtl/bus65_sync.sv
module bus65_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      safe_q <= RST_VAL;
    end else begin
      meta_q <= d;
      safe_q <= meta_q;
    end
  end

  assign q = safe_q;
endmodule

// File: rtl/bus65_phase.sv
module bus65_phase
  import bus65_pkg::*;
#(
  parameter int DLY_W     = 2,
  parameter bit HAS_DELAY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2_s,
  input  logic             delay_en,
  input  logic [DLY_W-1:0] delay_sel,
  output logic             start,
  output logic             fall
);
  logic phi2_d;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phi2_d <= 1'b0;
    else        phi2_d <= phi2_s;
  end

  assign rise = phi2_s & ~phi2_d;
  assign fall = ~phi2_s & phi2_d;

  generate
    if (HAS_DELAY) begin : g_delay
      phase_e           state_q;
      logic [DLY_W-1:0] cnt_q;
      logic [DLY_W-1:0] dly_eff;
      logic             cnt_done;

      assign dly_eff  = (delay_sel == '0) ? DLY_W'(1) : delay_sel;
      assign cnt_done = (state_q == PH_WAIT) && (cnt_q == DLY_W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          state_q <= PH_IDLE;
          cnt_q   <= '0;
        end else if (fall) begin
          state_q <= PH_IDLE;
          cnt_q   <= '0;
        end else begin
          case (state_q)
            PH_IDLE: begin
              if (rise) begin
                if (delay_en) begin
                  state_q <= PH_WAIT;
                  cnt_q   <= dly_eff;
                end else begin
                  state_q <= PH_HIGH;
                end
              end
            end
            PH_WAIT: begin
              if (cnt_done) state_q <= PH_HIGH;
              else          cnt_q   <= cnt_q - DLY_W'(1);
            end
            default: state_q <= state_q;
          endcase
        end
      end

      assign start = (rise & ~delay_en) | (cnt_done & ~fall);
    end else begin : g_direct
      assign start = rise;
    end
  endgenerate
endmodule

// File: rtl/bus65_ctrl.sv
module bus65_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fall,
  input  logic              sel_s,
  input  logic              rw_s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              act_rd,
  output logic              act_wr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              wr_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_rd   <= 1'b0;
      act_wr   <= 1'b0;
      cyc_addr <= '0;
    end else if (fall) begin
      act_rd <= 1'b0;
      act_wr <= 1'b0;
    end else if (start && sel_s) begin
      act_rd   <= rw_s;
      act_wr   <= ~rw_s;
      cyc_addr <= addr_s;
    end
  end

  assign wr_en = fall & act_wr;
endmodule

// File: rtl/bus65_regfile.sv
module bus65_regfile #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               regs[g] <= '0;
        else if (wr_en && addr == ADDR_W'(g))     regs[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/bus65_periph.sv
module bus65_periph #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int NUM_REGS  = 4,
  parameter int DLY_W     = 2,
  parameter bit HAS_DELAY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              rw,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              delay_en,
  input  logic [DLY_W-1:0]  delay_sel,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n
);
  localparam int SYNC_W = 3 + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {(ADDR_W + DATA_W){1'b0}}};

  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] sync_bus;
  logic              phi2_s;
  logic              rw_s;
  logic              cs_n_s;
  logic              sel_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              start;
  logic              fall;
  logic              act_rd;
  logic              act_wr;
  logic              wr_en;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] rd_data;

  assign raw_bus = {phi2, rw, cs_n, addr, data_in};
  assign {phi2_s, rw_s, cs_n_s, addr_s, data_s} = sync_bus;
  assign sel_s = ~cs_n_s;

  bus65_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  bus65_phase #(.DLY_W(DLY_W), .HAS_DELAY(HAS_DELAY)) u_phase (
    .clk(clk), .rst_n(rst_n), .phi2_s(phi2_s), .delay_en(delay_en),
    .delay_sel(delay_sel), .start(start), .fall(fall)
  );

  bus65_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fall(fall), .sel_s(sel_s),
    .rw_s(rw_s), .addr_s(addr_s), .act_rd(act_rd), .act_wr(act_wr),
    .cyc_addr(cyc_addr), .wr_en(wr_en)
  );

  bus65_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(cyc_addr),
    .wr_data(data_s), .rd_data(rd_data)
  );

  assign rd_strobe_n = ~act_rd;
  assign wr_strobe_n = ~act_wr;
  assign data_oe     = act_rd;
  assign data_out    = act_rd ? rd_data : '0;
endmodule

// File: rtl/bus65_periph_chk.sv
module bus65_periph_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe_n,
  input logic wr_strobe_n,
  input logic data_oe,
  input logic phi2_s,
  input logic sel_s,
  input logic wr_en
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n)); // R2

  AST_RD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_strobe_n) |-> $past(sel_s)); // R5

  AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_strobe_n) |-> $past(sel_s)); // R5

  AST_OE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(phi2_s)); // R3

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_oe) |-> !$past(phi2_s)); // R3

  AST_WR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!phi2_s && !wr_strobe_n)); // R4
endmodule

bind bus65_periph bus65_periph_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
  .data_oe(data_oe), .phi2_s(phi2_s), .sel_s(sel_s), .wr_en(wr_en)
);

// File: tb/sim_bus65_periph.sv
module sim_bus65_periph;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       phi2, rw, cs_n, delay_en;
  logic [2:0] addr;
  logic [1:0] delay_sel;
  logic [7:0] data_in;
  logic [7:0] data_out;
  logic       data_oe, rd_strobe_n, wr_strobe_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [4];

  always #10 clk = ~clk;

  bus65_periph u0 (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .cs_n(cs_n), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .delay_en(delay_en), .delay_sel(delay_sel),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int extra_of(input logic den, input logic [1:0] ds);
    if (!den) return 0;
    return (ds == 2'd0) ? 1 : int'(ds);
  endfunction

  function automatic logic [7:0] read_exp(input logic [2:0] a);
    return (a < 3'd4) ? model[a[1:0]] : 8'hFF;
  endfunction

  task automatic bus_cycle(input logic [2:0] a, input logic r, input logic sel,
                           input logic [7:0] d, input logic den, input logic [1:0] ds,
                           input int hi, input string dtag);
    int extra;
    logic valid, act;
    logic [7:0] exp_rd;
    extra  = extra_of(den, ds);
    valid  = (extra < hi);
    exp_rd = read_exp(a);
    @(negedge clk);
    addr = a; rw = r; cs_n = ~sel; data_in = d; delay_en = den; delay_sel = ds;
    repeat (3) @(negedge clk);
    phi2 = 1'b1;
    for (int i = 1; i <= hi + 5; i++) begin
      @(negedge clk);
      act = valid && sel && (i >= 3 + extra) && (i <= hi + 2);
      check(sel ? "R1 rd strobe" : "R5 rd strobe", {7'd0, rd_strobe_n}, {7'd0, ~(act && r)});
      check(sel ? "R2 wr strobe" : "R5 wr strobe", {7'd0, wr_strobe_n}, {7'd0, ~(act && !r)});
      check(den ? "R8 oe window" : "R3 oe window", {7'd0, data_oe}, {7'd0, act && r});
      if (act && r) check(dtag, data_out, exp_rd);
      if (i == hi) phi2 = 1'b0;
      if (i == hi + 1) data_in = ~d;
    end
    if (valid && sel && !r && a < 3'd4) model[a[1:0]] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; phi2 = 1'b0; rw = 1'b1; cs_n = 1'b1; addr = '0;
    data_in = '0; delay_en = 1'b0; delay_sel = '0;
    for (int k = 0; k < 4; k++) model[k] = 8'h00;
    repeat (4) @(negedge clk);
    check("R10 rd strobe", {7'd0, rd_strobe_n}, 8'd1);
    check("R10 wr strobe", {7'd0, wr_strobe_n}, 8'd1);
    check("R10 oe", {7'd0, data_oe}, 8'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 4; k++) bus_cycle(3'(k), 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R10 reset value");

    bus_cycle(3'd0, 1'b0, 1'b1, 8'hA5, 1'b0, 2'd0, 5, "R4");
    bus_cycle(3'd1, 1'b0, 1'b1, 8'h3C, 1'b0, 2'd0, 4, "R4");
    bus_cycle(3'd2, 1'b0, 1'b1, 8'h81, 1'b0, 2'd0, 6, "R4");
    bus_cycle(3'd3, 1'b0, 1'b1, 8'h7E, 1'b0, 2'd0, 3, "R4");
    for (int k = 0; k < 4; k++) bus_cycle(3'(k), 1'b1, 1'b1, 8'h55, 1'b0, 2'd0, 5, "R4 readback");

    bus_cycle(3'd6, 1'b0, 1'b1, 8'h99, 1'b0, 2'd0, 5, "R7");
    bus_cycle(3'd5, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R7 unimplemented");
    bus_cycle(3'd2, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R7 readback");

    bus_cycle(3'd1, 1'b0, 1'b0, 8'hEE, 1'b0, 2'd0, 5, "R5");
    bus_cycle(3'd1, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R5 readback");

    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cs_n = k[0]; rw = k[1]; addr = 3'(k); data_in = 8'(k * 17);
      check("R6 rd strobe", {7'd0, rd_strobe_n}, 8'd1);
      check("R6 wr strobe", {7'd0, wr_strobe_n}, 8'd1);
      check("R6 oe", {7'd0, data_oe}, 8'd0);
    end
    bus_cycle(3'd3, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R6 readback");

    for (int k = 0; k < 4; k++) bus_cycle(3'd0, 1'b1, 1'b1, 8'h00, 1'b1, 2'(k), 6, "R8 delayed read");
    bus_cycle(3'd2, 1'b0, 1'b1, 8'h11, 1'b1, 2'd2, 6, "R8");

    bus_cycle(3'd1, 1'b0, 1'b1, 8'hC3, 1'b1, 2'd3, 3, "R9");
    bus_cycle(3'd1, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R9 dropped write");
    bus_cycle(3'd1, 1'b0, 1'b1, 8'h5A, 1'b1, 2'd3, 4, "R9");
    bus_cycle(3'd1, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 5, "R9 late write");

    for (int n = 0; n < 80; n++) begin
      bus_cycle(3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)),
                ($urandom_range(3, 0) != 0), 8'($urandom_range(255, 0)),
                1'($urandom_range(1, 0)), 2'($urandom_range(3, 0)),
                int'($urandom_range(6, 1)), "R7 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule